// File: doc/BRIEF.md
# PCI Posted Write Target Acceptor

This block is the target-side front end of a bus bridge. It watches a PCI initiating bus for memory write and memory-write-and-invalidate transactions that an external decoder has marked for forwarding. It claims them with medium decode timing and takes the address and every data DWORD into a posted write queue at full bus rate. The far bus is never consulted during this. The queue is written through a simple push port: one entry per clock, with a flag that tells an address entry from a data entry and a tag on the final DWORD of each transaction.

The block keeps a running DWORD address and a private count of the queue space it may still use. From these it works out, one data phase ahead, whether the coming phase is the last one it may take. The last phase is the one that reaches the end of a cache line (memory-write-and-invalidate) or of an aligned 4 KB page (memory write), or the one that uses up the space. On that phase it raises a disconnect together with the data handshake, so that DWORD is still taken. It keeps the disconnect raised until the initiator drops FRAME#.

Top module: `pwt_acceptor`

## Requirements
- R1: Only command codes 4'b0111 (memory write) and 4'b1111 (memory-write-and-invalidate) are claimed, and only when `decode_hit` is high on the address-phase clock. Any other command, or no hit, gives no DEVSEL# and no queue push.
- R2: An address phase is the first clock with FRAME# low after a clock with it high. DEVSEL# goes low on the second clock after the address phase, and TRDY# goes low one clock after DEVSEL#.
- R3: A transaction is claimed only if `q_free` is at least 2 on the address-phase clock (room for the address entry and one DWORD).
- R4: Once TRDY# is low it stays low until the disconnect or final phase. Every clock edge with TRDY# and IRDY# both low pushes exactly one data entry on the next clock (`q_is_addr`=0), carrying `bus_ad` and `bus_cbe` of that edge. Clocks with IRDY# high push nothing.
- R5: The clock after a claimed address phase pushes one address entry with `q_is_addr`=1, `q_word` equal to the address and `q_be` equal to the command code.
- R6: When a data transfer happens with FRAME# high, the transaction ends. DEVSEL#, TRDY# and STOP# are all high on the next clock.
- R7: A disconnect drives STOP# low together with TRDY# on the last permitted data phase. After that transfer TRDY# goes high and takes no more data. STOP# and DEVSEL# stay low while FRAME# is low, and both go high the clock after FRAME# is sampled high.
- R8: For a memory write, the last permitted phase is the one whose address is the final DWORD of an aligned 4 KB page (address bits 11:2 all ones).
- R9: For memory-write-and-invalidate, the last permitted phase is the final DWORD of an aligned line of `line_dw` DWORDs (a power of two). A `line_dw` of zero selects the 4 KB page instead.
- R10: A claim grants `q_free`−1 data entries. The phase that would use the final one is the last permitted phase.
- R11: Exactly one entry per claimed transaction has `q_last`=1, and it is the final data entry, whether the end was normal or a disconnect.
- R12: While `rst` is high, DEVSEL#, TRDY# and STOP# are high and `q_push` is low, including when reset arrives in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_frame_n | input | 1 | FRAME#, active low |
| bus_irdy_n | input | 1 | IRDY#, active low |
| bus_ad | input | 32 | Multiplexed address/data |
| bus_cbe | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| decode_hit | input | 1 | External decoder says the address phase targets the far side |
| line_dw | input | LINE_W | Cache line size in DWORDs |
| q_free | input | FREE_W | Free entries in the posted write queue |
| tgt_devsel_n | output | 1 | DEVSEL#, active low |
| tgt_trdy_n | output | 1 | TRDY#, active low |
| tgt_stop_n | output | 1 | STOP#, active low |
| q_push | output | 1 | Queue write strobe |
| q_is_addr | output | 1 | Entry is an address entry |
| q_last | output | 1 | Entry is the final DWORD of its transaction |
| q_word | output | 32 | Entry address or data |
| q_be | output | 4 | Command (address entry) or byte enables (data entry) |

## Verification
A wrong running address or a wrong credit count does not hide. STOP# then rises one phase early or late, and the number of data entries in the queue differs from the count the boundary and space rules predict. This shows on the very burst where the count goes astray. A phase register stuck or skipped moves DEVSEL# or TRDY# off their fixed second and third clocks after the address phase, which is visible three clocks into the transaction. A lost end-of-transaction decision shows as a missing or misplaced last tag, or as handshake lines still low the clock after the final phase.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int AD_W  = 32;
    localparam int BE_W  = 4;
    localparam int IDX_W = AD_W - 2;

    localparam logic [BE_W-1:0] CMD_MEM_WR     = 4'b0111;
    localparam logic [BE_W-1:0] CMD_MEM_WR_INV = 4'b1111;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DECODE,
        PH_CLAIMED,
        PH_BURST,
        PH_DRAIN
    } pwt_phase_e;

    typedef struct packed {
        logic            is_addr;
        logic            last;
        logic [BE_W-1:0] be;
        logic [AD_W-1:0] word;
    } pwt_entry_t;

    typedef struct packed {
        logic devsel_n;
        logic trdy_n;
        logic stop_n;
    } pwt_tgt_drv_t;

    localparam pwt_tgt_drv_t DRV_RELEASED = '{devsel_n: 1'b1, trdy_n: 1'b1, stop_n: 1'b1};

    function automatic logic is_posted_cmd(input logic [BE_W-1:0] cmd);
        return (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_WR_INV);
    endfunction

    function automatic logic [IDX_W-1:0] low_ones(input int unsigned n);
        logic [IDX_W-1:0] m;
        for (int i = 0; i < IDX_W; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

    function automatic logic window_last(input logic [IDX_W-1:0] idx,
                                         input logic [IDX_W-1:0] mask);
        return (idx & mask) == mask;
    endfunction

endpackage

// File: rtl/pwt_claim.sv
module pwt_claim
    import pwt_pkg::*;
#(
    parameter int FREE_W = 8
) (
    input  logic              idle,
    input  logic              frame_n,
    input  logic              frame_prev_n,
    input  logic [BE_W-1:0]   cmd,
    input  logic              hit,
    input  logic [FREE_W-1:0] q_free,
    output logic              claim,
    output logic              claim_mwi
);
    localparam logic [FREE_W-1:0] MIN_ROOM = FREE_W'(2);

    logic addr_phase;

    always_comb begin
        addr_phase = frame_prev_n && !frame_n;
        claim      = idle && addr_phase && hit && is_posted_cmd(cmd) && (q_free >= MIN_ROOM);
        claim_mwi  = (cmd == CMD_MEM_WR_INV);
    end

endmodule

// File: rtl/pwt_window.sv
module pwt_window
    import pwt_pkg::*;
#(
    parameter int LINE_W       = 8,
    parameter int PAGE_DW_BITS = 10
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              use_line,
    input  logic [LINE_W-1:0] line_dw,
    output logic              at_end
);
    localparam logic [IDX_W-1:0] PAGE_MASK = low_ones(PAGE_DW_BITS);

    logic [IDX_W-1:0] line_mask;
    logic [IDX_W-1:0] mask;

    generate
        if (LINE_W < IDX_W) begin : g_line_pad
            assign line_mask = {{(IDX_W-LINE_W){1'b0}}, line_dw - LINE_W'(1)};
        end else begin : g_line_trunc
            assign line_mask = IDX_W'(line_dw - LINE_W'(1));
        end
    endgenerate

    always_comb begin
        // A line never reaches past its page: AND keeps the smaller power of two.
        if (use_line && (line_dw != '0)) begin
            mask = line_mask & PAGE_MASK;
        end else begin
            mask = PAGE_MASK;
        end
        at_end = window_last(idx, mask);
    end

endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
    import pwt_pkg::*;
#(
    parameter int FREE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              claim,
    input  logic              claim_mwi,
    input  logic [IDX_W-1:0]  claim_idx,
    input  logic [FREE_W-1:0] claim_free,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              probe_end,
    output logic [IDX_W-1:0]  probe_idx,
    output logic              mwi,
    output logic              idle,
    output logic              xfer,
    output logic              xfer_last,
    output pwt_tgt_drv_t      drv
);
    localparam logic [FREE_W-1:0] ONE_LEFT = FREE_W'(1);

    pwt_phase_e        phase_q;
    pwt_tgt_drv_t      drv_q;
    logic [IDX_W-1:0]  idx_q;
    logic [FREE_W-1:0] credit_q;
    logic              mwi_q;

    logic [FREE_W-1:0] probe_credit;
    logic              need_stop;

    always_comb begin
        idle      = (phase_q == PH_IDLE);
        xfer      = (phase_q == PH_BURST) && !irdy_n;
        xfer_last = xfer && (frame_n || !drv_q.stop_n);
        // During a burst the look-ahead is for the phase after the current one.
        if (phase_q == PH_BURST) begin
            probe_idx    = idx_q + IDX_W'(1);
            probe_credit = credit_q - ONE_LEFT;
        end else begin
            probe_idx    = idx_q;
            probe_credit = credit_q;
        end
        need_stop = probe_end || (probe_credit == ONE_LEFT);
        drv       = drv_q;
        mwi       = mwi_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            drv_q    <= DRV_RELEASED;
            idx_q    <= '0;
            credit_q <= '0;
            mwi_q    <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (claim) begin
                        phase_q  <= PH_DECODE;
                        idx_q    <= claim_idx;
                        credit_q <= claim_free - ONE_LEFT;
                        mwi_q    <= claim_mwi;
                    end
                end
                PH_DECODE: begin
                    drv_q.devsel_n <= 1'b0;
                    phase_q        <= PH_CLAIMED;
                end
                PH_CLAIMED: begin
                    drv_q.trdy_n <= 1'b0;
                    drv_q.stop_n <= !need_stop;
                    phase_q      <= PH_BURST;
                end
                PH_BURST: begin
                    if (xfer) begin
                        if (xfer_last) begin
                            if (frame_n) begin
                                drv_q   <= DRV_RELEASED;
                                phase_q <= PH_IDLE;
                            end else begin
                                drv_q.trdy_n <= 1'b1;
                                phase_q      <= PH_DRAIN;
                            end
                        end else begin
                            idx_q        <= probe_idx;
                            credit_q     <= probe_credit;
                            drv_q.stop_n <= !need_stop;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (frame_n) begin
                        drv_q   <= DRV_RELEASED;
                        phase_q <= PH_IDLE;
                    end
                end
                default: begin
                    drv_q   <= DRV_RELEASED;
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwt_qwrite.sv
module pwt_qwrite
    import pwt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            claim,
    input  logic            xfer,
    input  logic            xfer_last,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe,
    output logic            push,
    output pwt_entry_t      entry
);
    pwt_entry_t entry_q;
    logic       push_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            push_q  <= 1'b0;
            entry_q <= '0;
        end else begin
            push_q <= claim || xfer;
            if (claim) begin
                entry_q <= '{is_addr: 1'b1, last: 1'b0, be: cbe, word: ad};
            end else if (xfer) begin
                entry_q <= '{is_addr: 1'b0, last: xfer_last, be: cbe, word: ad};
            end
        end
    end

    assign push  = push_q;
    assign entry = entry_q;

endmodule

// File: rtl/pwt_acceptor.sv
module pwt_acceptor
    import pwt_pkg::*;
#(
    parameter int FREE_W     = 8,
    parameter int LINE_W     = 8,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_frame_n,
    input  logic              bus_irdy_n,
    input  logic [31:0]       bus_ad,
    input  logic [3:0]        bus_cbe,
    input  logic              decode_hit,
    input  logic [LINE_W-1:0] line_dw,
    input  logic [FREE_W-1:0] q_free,
    output logic              tgt_devsel_n,
    output logic              tgt_trdy_n,
    output logic              tgt_stop_n,
    output logic              q_push,
    output logic              q_is_addr,
    output logic              q_last,
    output logic [31:0]       q_word,
    output logic [3:0]        q_be
);
    localparam int PAGE_DW_BITS = $clog2(PAGE_BYTES) - 2;

    logic             frame_prev_n;
    logic             idle;
    logic             claim;
    logic             claim_mwi;
    logic             mwi;
    logic             xfer;
    logic             xfer_last;
    logic             probe_end;
    logic [IDX_W-1:0] probe_idx;
    pwt_tgt_drv_t     drv;
    pwt_entry_t       entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_prev_n <= 1'b1;
        end else begin
            frame_prev_n <= bus_frame_n;
        end
    end

    pwt_claim #(.FREE_W(FREE_W)) claim_i (
        .idle         (idle),
        .frame_n      (bus_frame_n),
        .frame_prev_n (frame_prev_n),
        .cmd          (bus_cbe),
        .hit          (decode_hit),
        .q_free       (q_free),
        .claim        (claim),
        .claim_mwi    (claim_mwi)
    );

    pwt_ctrl #(.FREE_W(FREE_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .claim      (claim),
        .claim_mwi  (claim_mwi),
        .claim_idx  (bus_ad[AD_W-1:2]),
        .claim_free (q_free),
        .frame_n    (bus_frame_n),
        .irdy_n     (bus_irdy_n),
        .probe_end  (probe_end),
        .probe_idx  (probe_idx),
        .mwi        (mwi),
        .idle       (idle),
        .xfer       (xfer),
        .xfer_last  (xfer_last),
        .drv        (drv)
    );

    pwt_window #(.LINE_W(LINE_W), .PAGE_DW_BITS(PAGE_DW_BITS)) window_i (
        .idx      (probe_idx),
        .use_line (mwi),
        .line_dw  (line_dw),
        .at_end   (probe_end)
    );

    pwt_qwrite qwrite_i (
        .clk       (clk),
        .rst       (rst),
        .claim     (claim),
        .xfer      (xfer),
        .xfer_last (xfer_last),
        .ad        (bus_ad),
        .cbe       (bus_cbe),
        .push      (q_push),
        .entry     (entry)
    );

    assign tgt_devsel_n = drv.devsel_n;
    assign tgt_trdy_n   = drv.trdy_n;
    assign tgt_stop_n   = drv.stop_n;
    assign q_is_addr    = entry.is_addr;
    assign q_last       = entry.last;
    assign q_word       = entry.word;
    assign q_be         = entry.be;

endmodule

// File: rtl/pwt_acceptor_chk.sv
module pwt_acceptor_chk #(
    parameter int FREE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_frame_n,
    input logic              bus_irdy_n,
    input logic [FREE_W-1:0] q_free,
    input logic              tgt_devsel_n,
    input logic              tgt_trdy_n,
    input logic              tgt_stop_n,
    input logic              q_push,
    input logic              q_is_addr,
    input logic              q_last
);

    AST_TRDY_UNDER_DEVSEL: assert property (@(posedge clk) disable iff (rst)
        !tgt_trdy_n |-> !tgt_devsel_n); // R4

    AST_STOP_UNDER_DEVSEL: assert property (@(posedge clk) disable iff (rst)
        !tgt_stop_n |-> !tgt_devsel_n); // R7

    AST_MEDIUM_DECODE: assert property (@(posedge clk) disable iff (rst)
        $fell(tgt_devsel_n) |-> ($past(bus_frame_n, 2) == 1'b0)); // R2

    AST_TRDY_NEXT_CLOCK: assert property (@(posedge clk) disable iff (rst)
        $fell(tgt_devsel_n) |=> $fell(tgt_trdy_n)); // R2

    AST_ROOM_AT_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (q_push && q_is_addr) |-> ($past(q_free) >= FREE_W'(2))); // R3

    AST_PUSH_PER_XFER: assert property (@(posedge clk) disable iff (rst)
        (!tgt_trdy_n && !bus_irdy_n) |=> (q_push && !q_is_addr)); // R4

    AST_STOP_HELD: assert property (@(posedge clk) disable iff (rst)
        (!tgt_stop_n && !bus_frame_n) |=> !tgt_stop_n); // R7

    AST_TRDY_DROP_AFTER_DISC: assert property (@(posedge clk) disable iff (rst)
        (!tgt_stop_n && !tgt_trdy_n && !bus_irdy_n && !bus_frame_n) |=> tgt_trdy_n); // R7

    AST_LAST_TAG_ON_FINAL: assert property (@(posedge clk) disable iff (rst)
        (!tgt_trdy_n && !bus_irdy_n && bus_frame_n) |=> (q_push && q_last)); // R11

    AST_RELEASE_AFTER_FINAL: assert property (@(posedge clk) disable iff (rst)
        (!tgt_trdy_n && !bus_irdy_n && bus_frame_n) |=> (tgt_devsel_n && tgt_trdy_n && tgt_stop_n)); // R6

    AST_RELEASE_AFTER_DISC: assert property (@(posedge clk) disable iff (rst)
        (!tgt_stop_n && tgt_trdy_n && bus_frame_n) |=> (tgt_stop_n && tgt_devsel_n)); // R7

endmodule

bind pwt_acceptor pwt_acceptor_chk #(.FREE_W(FREE_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_frame_n  (bus_frame_n),
    .bus_irdy_n   (bus_irdy_n),
    .q_free       (q_free),
    .tgt_devsel_n (tgt_devsel_n),
    .tgt_trdy_n   (tgt_trdy_n),
    .tgt_stop_n   (tgt_stop_n),
    .q_push       (q_push),
    .q_is_addr    (q_is_addr),
    .q_last       (q_last)
);

// File: tb/pwt_acceptor_tb_top.sv
module pwt_acceptor_tb_top;

    // One delay unit is 1 ns: the clock period is 10 units (100 MHz).
    localparam int FREE_W = 8;
    localparam int LINE_W = 8;

    typedef struct packed {
        logic [3:0]  cmd;
        logic        hit;
        logic [31:0] addr;
        logic [7:0]  free;
        logic [7:0]  line;
        logic [7:0]  nwords;
        logic [7:0]  exp_acc;   // 0 means the transaction must not be claimed
        logic        exp_stop;
        logic        gap;       // initiator inserts one IRDY# wait after the first DWORD
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'h7, 1'b1, 32'h0000_1000, 8'd16, 8'd8, 8'd4,  8'd4, 1'b0, 1'b0}, // R4 R6 plain burst
        '{4'h7, 1'b1, 32'h0000_1FF8, 8'd16, 8'd8, 8'd6,  8'd2, 1'b1, 1'b0}, // R8 page end
        '{4'hF, 1'b1, 32'h0000_2010, 8'd16, 8'd8, 8'd8,  8'd4, 1'b1, 1'b0}, // R9 line end
        '{4'hF, 1'b1, 32'h0000_2010, 8'd16, 8'd0, 8'd5,  8'd5, 1'b0, 1'b0}, // R9 zero line
        '{4'h7, 1'b1, 32'h0000_3000, 8'd3,  8'd8, 8'd6,  8'd2, 1'b1, 1'b0}, // R10 space
        '{4'h7, 1'b1, 32'h0000_3000, 8'd1,  8'd8, 8'd4,  8'd0, 1'b0, 1'b0}, // R3 no room
        '{4'h6, 1'b1, 32'h0000_3000, 8'd16, 8'd8, 8'd4,  8'd0, 1'b0, 1'b0}, // R1 read cmd
        '{4'h7, 1'b0, 32'h0000_3000, 8'd16, 8'd8, 8'd4,  8'd0, 1'b0, 1'b0}, // R1 no hit
        '{4'hF, 1'b1, 32'h0000_4004, 8'd16, 8'd4, 8'd2,  8'd2, 1'b0, 1'b0}, // R9 inside line
        '{4'hF, 1'b1, 32'h0000_400C, 8'd16, 8'd4, 8'd4,  8'd1, 1'b1, 1'b0}, // R9 first phase ends
        '{4'h7, 1'b1, 32'h0000_5000, 8'd16, 8'd8, 8'd1,  8'd1, 1'b0, 1'b0}, // R6 single
        '{4'h7, 1'b1, 32'h0000_5000, 8'd2,  8'd8, 8'd3,  8'd1, 1'b1, 1'b0}, // R10 one credit
        '{4'hF, 1'b1, 32'h0000_6000, 8'd16, 8'd8, 8'd20, 8'd8, 1'b1, 1'b0}, // R9 whole line
        '{4'h7, 1'b1, 32'h0000_6FF0, 8'd40, 8'd8, 8'd10, 8'd4, 1'b1, 1'b0}, // R8 page tail
        '{4'h7, 1'b1, 32'h0000_8000, 8'd16, 8'd8, 8'd4,  8'd4, 1'b0, 1'b1}  // R4 wait state
    };

    logic              clk;
    logic              rst;
    logic              bus_frame_n;
    logic              bus_irdy_n;
    logic [31:0]       bus_ad;
    logic [3:0]        bus_cbe;
    logic              decode_hit;
    logic [LINE_W-1:0] line_dw;
    logic [FREE_W-1:0] q_free;
    logic              tgt_devsel_n;
    logic              tgt_trdy_n;
    logic              tgt_stop_n;
    logic              q_push;
    logic              q_is_addr;
    logic              q_last;
    logic [31:0]       q_word;
    logic [3:0]        q_be;

    int errors = 0;
    int checks = 0;
    int wd     = 0;

    // queue monitor state
    int          mon_addr_cnt;
    int          mon_data_cnt;
    int          mon_last_cnt;
    int          mon_last_idx;
    int          mon_mism;
    logic [31:0] mon_addr_word;
    logic [3:0]  mon_addr_be;

    pwt_acceptor #(.FREE_W(FREE_W), .LINE_W(LINE_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_frame_n  (bus_frame_n),
        .bus_irdy_n   (bus_irdy_n),
        .bus_ad       (bus_ad),
        .bus_cbe      (bus_cbe),
        .decode_hit   (decode_hit),
        .line_dw      (line_dw),
        .q_free       (q_free),
        .tgt_devsel_n (tgt_devsel_n),
        .tgt_trdy_n   (tgt_trdy_n),
        .tgt_stop_n   (tgt_stop_n),
        .q_push       (q_push),
        .q_is_addr    (q_is_addr),
        .q_last       (q_last),
        .q_word       (q_word),
        .q_be         (q_be)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [31:0] data_word(input int i);
        return 32'hD000_0000 | 32'(i);
    endfunction

    function automatic logic [3:0] data_be(input int i);
        return 4'(i * 3);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic mon_clear();
        mon_addr_cnt  = 0;
        mon_data_cnt  = 0;
        mon_last_cnt  = 0;
        mon_last_idx  = 0;
        mon_mism      = 0;
        mon_addr_word = '0;
        mon_addr_be   = '0;
    endtask

    always @(negedge clk) begin
        if (!rst && q_push) begin
            if (q_is_addr) begin
                mon_addr_cnt++;
                mon_addr_word = q_word;
                mon_addr_be   = q_be;
            end else begin
                if (q_word != data_word(mon_data_cnt) || q_be != data_be(mon_data_cnt)) begin
                    mon_mism++;
                end
                mon_data_cnt++;
                if (q_last) begin
                    mon_last_cnt++;
                    mon_last_idx = mon_data_cnt;
                end
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Initiator model: drives on falling edges, reads outputs held for the next rising edge.
    task automatic run_txn(input vec_t v, output int acc, output bit stopped,
                           output int dev_lat, output int trdy_lat);
        bit done;
        bit gap_now;
        bit tr_s;
        bit st_s;
        bit dv_s;
        int cyc;
        int i;
        acc = 0; stopped = 0; dev_lat = 0; trdy_lat = 0;
        done = 0; gap_now = 0; cyc = 0; i = 0;
        @(negedge clk);
        bus_frame_n = 1'b0; bus_irdy_n = 1'b1;
        bus_ad = v.addr; bus_cbe = v.cmd; decode_hit = v.hit;
        q_free = v.free; line_dw = v.line;
        @(negedge clk);
        decode_hit  = 1'b0;
        bus_irdy_n  = 1'b0;
        bus_frame_n = (v.nwords == 8'd1);
        bus_ad = data_word(0); bus_cbe = data_be(0);
        cyc = 1;
        tr_s = tgt_trdy_n; st_s = tgt_stop_n; dv_s = tgt_devsel_n;
        while (!done) begin
            if (!dv_s && dev_lat == 0) dev_lat = cyc;
            if (!tr_s && trdy_lat == 0) trdy_lat = cyc;
            @(negedge clk);
            cyc++;
            if (!tr_s && !bus_irdy_n) begin
                acc++; i++;
                if (!st_s) stopped = 1;
                if (bus_frame_n) begin
                    done = 1;
                end else if (!st_s) begin
                    bus_frame_n = 1'b1;
                end else begin
                    bus_ad = data_word(i); bus_cbe = data_be(i);
                    if (i == int'(v.nwords) - 1) bus_frame_n = 1'b1;
                    if (v.gap && acc == 1) begin
                        bus_irdy_n = 1'b1; gap_now = 1;
                    end
                end
            end else if (gap_now) begin
                bus_irdy_n = 1'b0; gap_now = 0;
            end else if (!st_s) begin
                stopped = 1;
                if (bus_frame_n) done = 1;
                else bus_frame_n = 1'b1;
            end else if (dv_s && cyc > 5) begin
                done = 1;
            end
            if (done) begin
                bus_frame_n = 1'b1; bus_irdy_n = 1'b1;
            end
            tr_s = tgt_trdy_n; st_s = tgt_stop_n; dv_s = tgt_devsel_n;
        end
    endtask

    initial begin
        rst = 1'b1;
        bus_frame_n = 1'b1; bus_irdy_n = 1'b1;
        bus_ad = '0; bus_cbe = '0; decode_hit = 1'b0;
        line_dw = 8'd8; q_free = 8'd16;
        mon_clear();
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(tgt_devsel_n && tgt_trdy_n && tgt_stop_n, "R12", "handshake idle in reset",
            {tgt_devsel_n, tgt_trdy_n, tgt_stop_n}, 7);
        chk(q_push == 1'b0, "R12", "no push in reset", q_push, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // table walk
        for (int k = 0; k < NV; k++) begin
            int  acc;
            bit  stopped;
            int  dev_lat;
            int  trdy_lat;
            bit  released;
            mon_clear();
            run_txn(VECS[k], acc, stopped, dev_lat, trdy_lat);
            released = tgt_devsel_n && tgt_trdy_n && tgt_stop_n;
            @(negedge clk);
            if (VECS[k].exp_acc == 8'd0) begin
                chk(dev_lat == 0, "R1/R3", $sformatf("vec %0d not claimed", k), dev_lat, 0);
                chk(mon_addr_cnt + mon_data_cnt == 0, "R1/R3", $sformatf("vec %0d no push", k),
                    mon_addr_cnt + mon_data_cnt, 0);
            end else begin
                chk(dev_lat == 2, "R2", $sformatf("vec %0d DEVSEL# clock", k), dev_lat, 2);
                chk(trdy_lat == 3, "R2", $sformatf("vec %0d TRDY# clock", k), trdy_lat, 3);
                chk(acc == int'(VECS[k].exp_acc), "R4/R8/R9/R10",
                    $sformatf("vec %0d DWORDs taken", k), acc, VECS[k].exp_acc);
                chk(stopped == VECS[k].exp_stop, "R7", $sformatf("vec %0d disconnect", k),
                    stopped, VECS[k].exp_stop);
                chk(mon_addr_cnt == 1 && mon_addr_word == VECS[k].addr && mon_addr_be == VECS[k].cmd,
                    "R5", $sformatf("vec %0d address entry", k), mon_addr_word, VECS[k].addr);
                chk(mon_data_cnt == acc && mon_mism == 0, "R4",
                    $sformatf("vec %0d data entries", k), mon_data_cnt, acc);
                chk(mon_last_cnt == 1 && mon_last_idx == acc, "R11",
                    $sformatf("vec %0d last tag position", k), mon_last_idx, acc);
                chk(released, "R6/R7", $sformatf("vec %0d released", k), released, 1);
            end
            @(negedge clk);
        end

        // R7 directed: initiator keeps FRAME# low after a disconnect on the page's final DWORD
        mon_clear();
        @(negedge clk);
        bus_frame_n = 1'b0; bus_ad = 32'h0000_9FFC; bus_cbe = 4'h7; decode_hit = 1'b1;
        q_free = 8'd16;
        @(negedge clk);
        decode_hit = 1'b0; bus_irdy_n = 1'b0; bus_ad = data_word(0); bus_cbe = data_be(0);
        @(negedge clk);
        @(negedge clk);
        chk(!tgt_trdy_n && !tgt_stop_n, "R7", "STOP# with TRDY# on boundary phase",
            {tgt_trdy_n, tgt_stop_n}, 0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(tgt_trdy_n && !tgt_stop_n && !tgt_devsel_n, "R7", "STOP# held while FRAME# low",
                {tgt_devsel_n, tgt_trdy_n, tgt_stop_n}, 3'b010);
        end
        bus_frame_n = 1'b1;
        @(negedge clk);
        bus_irdy_n = 1'b1;
        chk(tgt_devsel_n && tgt_stop_n, "R7", "release after FRAME# high",
            {tgt_devsel_n, tgt_stop_n}, 3);
        chk(mon_data_cnt == 1, "R7", "one DWORD taken on disconnect", mon_data_cnt, 1);

        // R12 directed: reset in the middle of a burst
        repeat (2) @(negedge clk);
        bus_frame_n = 1'b0; bus_ad = 32'h0000_A000; bus_cbe = 4'h7; decode_hit = 1'b1;
        @(negedge clk);
        decode_hit = 1'b0; bus_irdy_n = 1'b0; bus_ad = data_word(0);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(tgt_devsel_n && tgt_trdy_n && tgt_stop_n && !q_push, "R12", "reset mid-burst",
            {tgt_devsel_n, tgt_trdy_n, tgt_stop_n, q_push}, 4'b1110);
        bus_frame_n = 1'b1; bus_irdy_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule